// File: doc/BRIEF.md
# Gray-Coded Event Counter in Byte-Wide Storage

This block keeps a 16-bit event counter in an external byte-wide memory. It holds the count in Gray code and gives every Gray bit a byte of its own: a byte of all ones stands for a one and a byte of all zeros for a zero. Consecutive Gray values differ in one bit, so each increment rewrites exactly one byte. A write that is cut short or corrupted can leave the count at its old value or move it to the new one. It cannot leave any other value.

After reset, and whenever `load_req` is raised, the block reads the sixteen bit-bytes in order. It decodes each byte by counting its set bits against the threshold input, then rebuilds the Gray count and the binary count from the results. On `incr_req` it works out which Gray bit changes next and writes only that bit's byte. A one-cycle `done` pulse ends each load and each increment.

The sequencer has five states. BOOT is the reset state and moves to LOAD without a condition. LOAD stays in LOAD on each acknowledged read except the last; the last acknowledged read moves it to FINISH. IDLE moves to LOAD on `load_req`, or otherwise to WRITE on `incr_req`. WRITE moves to FINISH when its write is acknowledged. FINISH returns to IDLE after one cycle.

Top module: `gray_byte_counter`

## Requirements
- R1: Gray bit i is stored at address `base_addr + i` (i = 0..15). A write drives `mem_wdata` = 0xFF for a one and 0x00 for a zero.
- R2: Each accepted increment issues exactly one memory write, to the byte of the single Gray bit that changes. When `done` rises, `bin_count` has advanced by one, modulo 2^16.
- R3: The Gray bit to flip is bit 0 when the Gray value has even parity (even binary count). Otherwise it is the bit just above the lowest set Gray bit. When that lowest set bit is bit 15 (Gray 0x8000, binary 0xFFFF), bit 15 flips and the count wraps to 0.
- R4: On a read, the bit decodes as one exactly when the number of set bits in the returned byte is at least `thresh` (0..8), sampled when the byte arrives.
- R5: `bin_count[15]` = `gray_count[15]`, and `bin_count[i]` = `bin_count[i+1]` XOR `gray_count[i]` for lower bits.
- R6: A load, both the one after reset and one on `load_req`, performs sixteen reads at addresses `base_addr` to `base_addr+15` in ascending order and no write.
- R7: `done` is high for exactly one cycle at the end of each load and each increment. `busy` is high from reset or from accepting a request until the cycle after `done`. In reset, `mem_req` and `done` are low and `busy` is high.
- R8: When `load_req` and `incr_req` are high together in IDLE, the load is taken and no write occurs. Requests made while `busy` is high are ignored.
- R9: If the write of an increment is lost or garbled, the count rebuilt by the next load equals either the old or the new value.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack`. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Rebuild the count from memory |
| incr_req | input | 1 | Advance the count by one |
| thresh | input | 4 | Minimum set-bit count for a byte to read as one |
| base_addr | input | 16 | Address of the byte for Gray bit 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write byte (0x00 or 0xFF) |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 8 | Read byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| gray_count | output | 16 | Count in Gray code |
| bin_count | output | 16 | Count in binary |

## Verification
The bench builds the block with its default parameters: a 16-bit count, 8-bit bytes and 16-bit addresses, with the bit-bytes placed from address 0x0008. With these values the bench can preset memory directly to the wrap point 0xFFFF and step through a run of increments that covers many different flip positions. It can also exercise thresholds from 0 to 8 against partly corrupted bytes. A memory model that can drop or garble a single write makes the old-or-new recovery property observable after a reload.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
    // Sequencer states
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LOAD,
        ST_IDLE,
        ST_WRITE,
        ST_FINISH
    } gbc_state_e;
endpackage

// File: rtl/gbc_bit_decode.sv
// Threshold decoder: a stored byte reads as one when enough of its bits are set.
module gbc_bit_decode #(
    parameter int BYTE_W = 8,
    parameter int TH_W   = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [TH_W-1:0]   thresh_i,
    output logic              bit_o
);
    logic [TH_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            ones = ones + TH_W'(byte_i[i]);
        end
        bit_o = (ones >= thresh_i);
    end
endmodule

// File: rtl/gbc_gray2bin.sv
// Gray to binary: running XOR from the top bit downward.
module gbc_gray2bin #(
    parameter int W = 16
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    assign bin_o[W-1] = gray_i[W-1];

    for (genvar i = W - 2; i >= 0; i--) begin : g_chain
        assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
endmodule

// File: rtl/gbc_flip_sel.sv
// Selects the Gray bit that changes on the next increment.
module gbc_flip_sel #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     gray_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] low;

    always_comb begin
        low = IDX_W'(W - 1);
        for (int i = W - 1; i >= 0; i--) begin
            if (gray_i[i]) low = IDX_W'(i);
        end
        if (!(^gray_i)) begin
            idx_o = '0;                      // even count: lowest bit
        end else if (low == IDX_W'(W - 1)) begin
            idx_o = low;                     // wrap from the last value
        end else begin
            idx_o = low + IDX_W'(1);         // bit above lowest set bit
        end
    end
endmodule

// File: rtl/gray_byte_counter.sv
module gray_byte_counter
    import gbc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(CNT_W),
    localparam int TH_W  = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              incr_req,
    input  logic [TH_W-1:0]   thresh,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  gray_count,
    output logic [CNT_W-1:0]  bin_count
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CNT_W - 1);

    gbc_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  flip_q;
    logic              new_bit_q;
    logic [CNT_W-1:0]  gray_q;
    logic [IDX_W-1:0]  flip_idx;
    logic              dec_bit;

    gbc_bit_decode #(.BYTE_W(BYTE_W), .TH_W(TH_W)) u_decode (
        .byte_i   (mem_rdata),
        .thresh_i (thresh),
        .bit_o    (dec_bit)
    );

    gbc_flip_sel #(.W(CNT_W), .IDX_W(IDX_W)) u_flip (
        .gray_i (gray_q),
        .idx_o  (flip_idx)
    );

    gbc_gray2bin #(.W(CNT_W)) u_g2b (
        .gray_i (gray_q),
        .bin_o  (bin_count)
    );

    assign gray_count = gray_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_LOAD;
            ST_LOAD:   if (mem_ack && idx_q == LAST_IDX) state_d = ST_FINISH;
            ST_IDLE: begin
                if (load_req)      state_d = ST_LOAD;
                else if (incr_req) state_d = ST_WRITE;
            end
            ST_WRITE:  if (mem_ack) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_BOOT;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            flip_q    <= '0;
            new_bit_q <= 1'b0;
            gray_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (!load_req && incr_req) begin
                        flip_q    <= flip_idx;
                        new_bit_q <= ~gray_q[flip_idx];
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        gray_q[idx_q] <= dec_bit;
                        idx_q         <= idx_q + IDX_W'(1);
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) gray_q[flip_q] <= new_bit_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = (state_q == ST_LOAD) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = base_addr + ADDR_W'((state_q == ST_WRITE) ? flip_q : idx_q);
        mem_wdata = {BYTE_W{new_bit_q}};
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
    end

    // R2: a completed write changes exactly one Gray bit
    a_r2_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && mem_ack) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

    // R2: binary value advances by one per increment
    a_r2_bin_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && mem_ack) |=> (bin_count == CNT_W'($past(bin_count) + 1)));

    // R1: written bytes are all zeros or all ones
    a_r1_solid_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1));

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: request held stable until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R8: a load request in IDLE wins
    a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && load_req) |=> (state_q == ST_LOAD));
endmodule

// File: tb/gray_byte_counter_tb.sv
`timescale 1ns/1ps
module gray_byte_counter_tb;
    localparam int BASE = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_req, incr_req;
    logic [3:0]  thresh;
    logic [15:0] base_addr;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] gray_count, bin_count;

    // memory model controls
    logic        bd_we = 1'b0;
    logic [4:0]  bd_addr = '0;
    logic [7:0]  bd_data = '0;
    logic        drop_wr = 1'b0;
    logic        garble_en = 1'b0;
    logic [7:0]  garble_val = '0;
    logic [7:0]  mem [0:31];
    logic [15:0] rd_log [0:31];
    int          rd_cnt = 0;
    int          wr_cnt = 0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gray_byte_counter u_dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .incr_req(incr_req),
        .thresh(thresh), .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .gray_count(gray_count), .bin_count(bin_count)
    );

    // Byte memory: acknowledges one cycle after each request
    always @(posedge clk) begin
        if (bd_we) mem[bd_addr] <= bd_data;
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    wr_cnt <= wr_cnt + 1;
                    if (!drop_wr) mem[mem_addr[4:0]] <= garble_en ? garble_val : mem_wdata;
                end else begin
                    rd_log[rd_cnt % 32] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
                mem_rdata <= mem[mem_addr[4:0]];
            end
        end
    end

    // gray[15:0], one_byte, zero_byte, thresh, expected decoded gray
    localparam int NV = 7;
    localparam logic [51:0] VEC [NV] = '{
        {16'h0000, 8'hFF, 8'h00, 4'd4, 16'h0000},
        {16'hA5C3, 8'hFF, 8'h00, 4'd4, 16'hA5C3},
        {16'h1234, 8'hF0, 8'h07, 4'd4, 16'h1234},
        {16'h1234, 8'hE0, 8'h00, 4'd4, 16'h0000},
        {16'h00FF, 8'h01, 8'h00, 4'd1, 16'h00FF},
        {16'h8001, 8'hFF, 8'h00, 4'd0, 16'hFFFF},
        {16'h4000, 8'hFF, 8'h7F, 4'd8, 16'h4000}
    };

    function automatic logic [15:0] to_bin(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [15:0] to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        bd_addr = a[4:0];
        bd_data = d;
        bd_we   = 1'b1;
        @(negedge clk);
        bd_we   = 1'b0;
    endtask

    task automatic preset(input logic [15:0] g, input logic [7:0] one_b, input logic [7:0] zero_b);
        for (int i = 0; i < 16; i++) poke(BASE + i, g[i] ? one_b : zero_b);
    endtask

    task automatic wait_done(input string rq);
        bit seen = 1'b0;
        for (int n = 0; n < 3000 && !seen; n++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen, rq, "done seen", 32'(seen), 32'd1);
        @(negedge clk);
        chk(!done, "R7", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic do_load(input string rq);
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        wait_done(rq);
    endtask

    task automatic do_incr(input string rq);
        @(negedge clk);
        incr_req = 1'b1;
        @(negedge clk);
        incr_req = 1'b0;
        wait_done(rq);
    endtask

    task automatic check_reads(input int start);
        chk(rd_cnt - start == 16, "R6", "read count", 32'(rd_cnt - start), 32'd16);
        for (int i = 0; i < 16; i++)
            chk(rd_log[(start + i) % 32] == 16'(BASE + i), "R6", "read order",
                32'(rd_log[(start + i) % 32]), 32'(BASE + i));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rs, ws;
        logic [15:0] b, g_old, g_new, diff;
        logic [7:0] snap [0:15];

        rst_n = 1'b0;
        load_req = 1'b0;
        incr_req = 1'b0;
        thresh = 4'd4;
        base_addr = 16'(BASE);
        for (int i = 0; i < 32; i++) poke(i, 8'h00);
        preset(to_gray(16'd5), 8'hFF, 8'h00);
        repeat (2) @(negedge clk);
        // R7: reset state
        chk(!mem_req, "R7", "mem_req in reset", 32'(mem_req), 32'd0);
        chk(!done, "R7", "done in reset", 32'(done), 32'd0);
        chk(busy, "R7", "busy in reset", 32'(busy), 32'd1);
        rs = rd_cnt;
        ws = wr_cnt;
        rst_n = 1'b1;
        wait_done("R6");
        chk(bin_count == 16'd5, "R6", "boot load value", 32'(bin_count), 32'd5);
        chk(wr_cnt == ws, "R6", "no write on load", 32'(wr_cnt), 32'(ws));
        check_reads(rs);
        chk(!busy, "R7", "idle after done", 32'(busy), 32'd0);

        // Table of load vectors (R4, R5)
        for (int v = 0; v < NV; v++) begin
            preset(VEC[v][51:36], VEC[v][35:28], VEC[v][27:20]);
            thresh = VEC[v][19:16];
            rs = rd_cnt;
            do_load("R4");
            chk(gray_count == VEC[v][15:0], "R4", "decoded gray", 32'(gray_count), 32'(VEC[v][15:0]));
            chk(bin_count == to_bin(VEC[v][15:0]), "R5", "binary from gray",
                32'(bin_count), 32'(to_bin(VEC[v][15:0])));
            check_reads(rs);
        end

        // Increment run from 5 (R1, R2, R3)
        thresh = 4'd4;
        preset(to_gray(16'd5), 8'hFF, 8'h00);
        do_load("R6");
        for (int k = 0; k < 40; k++) begin
            b = bin_count;
            g_old = to_gray(b);
            g_new = to_gray(b + 16'd1);
            diff = g_old ^ g_new;
            for (int i = 0; i < 16; i++) snap[i] = mem[BASE + i];
            ws = wr_cnt;
            do_incr("R2");
            chk(wr_cnt - ws == 1, "R2", "one write", 32'(wr_cnt - ws), 32'd1);
            chk(bin_count == b + 16'd1, "R2", "binary step", 32'(bin_count), 32'(b + 16'd1));
            for (int i = 0; i < 16; i++) begin
                if (diff[i]) begin
                    chk(mem[BASE + i] == (g_new[i] ? 8'hFF : 8'h00), "R3", "flipped byte",
                        32'(mem[BASE + i]), g_new[i] ? 32'hFF : 32'h0);
                end else if (mem[BASE + i] != snap[i]) begin
                    chk(1'b0, "R1", "untouched byte", 32'(mem[BASE + i]), 32'(snap[i]));
                end
            end
        end

        // Wrap at 0xFFFF (R3)
        preset(16'h8000, 8'hFF, 8'h00);
        do_load("R3");
        chk(bin_count == 16'hFFFF, "R3", "wrap preload", 32'(bin_count), 32'hFFFF);
        ws = wr_cnt;
        do_incr("R3");
        chk(bin_count == 16'h0000, "R3", "wrap to zero", 32'(bin_count), 32'h0);
        chk(mem[BASE + 15] == 8'h00, "R3", "msb byte cleared", 32'(mem[BASE + 15]), 32'h0);
        chk(wr_cnt - ws == 1, "R3", "single wrap write", 32'(wr_cnt - ws), 32'd1);

        // Lost and garbled writes (R9); count 6 -> 7 flips bit 0 from 1 to 0
        preset(to_gray(16'd6), 8'hFF, 8'h00);
        do_load("R9");
        drop_wr = 1'b1;
        do_incr("R9");
        drop_wr = 1'b0;
        do_load("R9");
        chk(bin_count == 16'd6, "R9", "lost write keeps old", 32'(bin_count), 32'd6);
        garble_en = 1'b1;
        garble_val = 8'hF0;
        do_incr("R9");
        do_load("R9");
        chk(bin_count == 16'd6, "R9", "garbled 0xF0 reads old", 32'(bin_count), 32'd6);
        garble_val = 8'h07;
        do_incr("R9");
        garble_en = 1'b0;
        do_load("R9");
        chk(bin_count == 16'd7, "R9", "garbled 0x07 reads new", 32'(bin_count), 32'd7);

        // Simultaneous requests: load wins (R8)
        ws = wr_cnt;
        rs = rd_cnt;
        @(negedge clk);
        load_req = 1'b1;
        incr_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        incr_req = 1'b0;
        wait_done("R8");
        chk(wr_cnt == ws, "R8", "no write when both requested", 32'(wr_cnt), 32'(ws));
        chk(rd_cnt - rs == 16, "R8", "load taken", 32'(rd_cnt - rs), 32'd16);
        chk(bin_count == 16'd7, "R8", "value after load", 32'(bin_count), 32'd7);

        // Increment during a load is ignored (R8)
        ws = wr_cnt;
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        repeat (3) @(negedge clk);
        incr_req = 1'b1;
        @(negedge clk);
        incr_req = 1'b0;
        wait_done("R8");
        repeat (10) begin
            @(negedge clk);
            if (done || busy) chk(1'b0, "R8", "no late operation", 32'(busy), 32'd0);
        end
        chk(wr_cnt == ws, "R8", "busy incr ignored", 32'(wr_cnt), 32'(ws));
        chk(bin_count == 16'd7, "R8", "count unchanged", 32'(bin_count), 32'd7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule